// File: doc/BRIEF.md
# Seven-to-One Pixel Link Serializer

This block turns one parallel pixel word per pixel period into three serial data lanes plus a forwarded clock lane. The word is 21 bits wide: 18 colour bits (six each of red, green and blue) and three timing bits (horizontal sync, vertical sync and data enable). Each lane carries seven bit slots per pixel period, evenly spaced, so the block runs on a bit clock seven times the pixel rate. At a 65 MHz pixel clock, for example, that is 455 Mbit/s per lane.

A load pulse, one bit clock wide and repeating every seven bit clocks, marks the start of each pixel period. The word present on that edge is captured. This stands in for the falling-edge strobe of the parallel pixel clock. The clock lane repeats a fixed seven-slot shape aligned to each captured word.

An active-low power-down input takes the link off the wire. The lanes are held idle and an output-enable flag drops, which models the high-impedance state. The analog signalling and the clock synthesis sit outside this block.

Top module: `pxl_link_ser`

## Requirements
- R1: While rst_n is low, laneData is all zero, clkLane is 0 and outEn is 0.
- R2: A clock edge with loadPulse=1 and pwrDownN=1 captures pixWord. In the cycle after that edge, slot 0 of the new word is on the lanes. Slot k appears k cycles later, for k from 0 to 6.
- R3: Lane l carries pixWord bits 7l to 7l+6, least significant first: slot k of lane l is pixWord[7l+k]. Lane 0 therefore carries bits 0..6, lane 1 bits 7..13 and lane 2 bits 14..20.
- R4: clkLane is 1 in slots 0 to 3 of every captured word and 0 in slots 4 to 6.
- R5: If no new load is accepted, then from the eighth cycle after a load onward, laneData and clkLane are 0.
- R6: outEn is 1 in the cycle after any edge that samples pwrDownN=1.
- R7: An edge that samples pwrDownN=0 drives outEn, laneData and clkLane to 0 from the next cycle. The word in flight is discarded: when pwrDownN returns high, the lanes stay 0 until the next load.
- R8: A loadPulse sampled while pwrDownN=0 is ignored. No word from it ever reaches the lanes.
- R9: A load accepted before the current word has finished restarts at slot 0 with the new word. The rest of the old word is dropped.
- R10: pixWord is ignored on edges without an accepted load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock, seven times the pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| loadPulse | input | 1 | Marks the bit-clock edge that captures a new pixel word |
| pwrDownN | input | 1 | Active-low power-down |
| pixWord | input | 21 | Parallel pixel word: 18 colour bits and 3 timing bits |
| laneData | output | 3 | Serial data lanes, one bit per lane per slot |
| clkLane | output | 1 | Forwarded clock lane pattern |
| outEn | output | 1 | Lane output enable; low models the disabled link |

## Verification
The bench uses walking-one words to tie every input bit to its lane and slot. A design with swapped groups, or one that sends most significant first, puts the single one in the wrong place. Back-to-back loads show whether a word loses or repeats its last slot at the boundary. An early reload shows whether leftover bits of the old word leak into the new one. Power-down is driven in the middle of a word, with loads and changing data held on the inputs, and the link must stay silent after it wakes. A design that kept its shift contents, or that accepted loads while down, would resume or emit stale bits.

// File: rtl/pxl_ser_pkg.sv
package pxl_ser_pkg;

  // Strobes from the control to the datapath, one set per bit clock.
  typedef struct packed {
    logic loadWord;   // capture the parallel word and restart the slots
    logic shiftOn;    // advance every lane by one slot
    logic clearAll;   // flush all lanes to idle
  } serStrobe_t;

endpackage

// File: rtl/pxl_ser_ctrl.sv
module pxl_ser_ctrl
  import pxl_ser_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       loadPulse,
  input  logic       pwrDownN,
  output serStrobe_t strobes,
  output logic       outEn
);

  // The output enable follows the power-down input, one edge later.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) outEn <= 1'b0;
    else        outEn <= pwrDownN;
  end

  // While powered down, loads are refused and the lanes are flushed.
  always_comb begin
    strobes          = '0;
    strobes.clearAll = !pwrDownN;
    strobes.loadWord = pwrDownN && loadPulse;
    strobes.shiftOn  = pwrDownN && !loadPulse;
  end

endmodule

// File: rtl/pxl_ser_dp.sv
module pxl_ser_dp
  import pxl_ser_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int SLOTS      = 7,
  parameter int HIGH_SLOTS = 4,
  localparam int WORD_W    = LANES * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  serStrobe_t        strobes,
  input  logic [WORD_W-1:0] pixWord,
  output logic [LANES-1:0]  laneData,
  output logic              clkLane
);

  // Clock shape, least significant slot first: HIGH_SLOTS ones, then zeros.
  localparam logic [SLOTS-1:0] CLK_SHAPE =
    {{(SLOTS-HIGH_SLOTS){1'b0}}, {HIGH_SLOTS{1'b1}}};

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [SLOTS-1:0] shReg;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                shReg <= '0;
      else if (strobes.clearAll) shReg <= '0;
      else if (strobes.loadWord) shReg <= pixWord[l*SLOTS +: SLOTS];
      else if (strobes.shiftOn)  shReg <= {1'b0, shReg[SLOTS-1:1]};
    end

    assign laneData[l] = shReg[0];
  end

  logic [SLOTS-1:0] clkReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                clkReg <= '0;
    else if (strobes.clearAll) clkReg <= '0;
    else if (strobes.loadWord) clkReg <= CLK_SHAPE;
    else if (strobes.shiftOn)  clkReg <= {1'b0, clkReg[SLOTS-1:1]};
  end

  assign clkLane = clkReg[0];

endmodule

// File: rtl/pxl_link_ser.sv
module pxl_link_ser
  import pxl_ser_pkg::*;
#(
  parameter int LANES      = 3,
  parameter int SLOTS      = 7,
  parameter int HIGH_SLOTS = 4,
  localparam int WORD_W    = LANES * SLOTS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              loadPulse,
  input  logic              pwrDownN,
  input  logic [WORD_W-1:0] pixWord,
  output logic [LANES-1:0]  laneData,
  output logic              clkLane,
  output logic              outEn
);

  serStrobe_t strobes;

  pxl_ser_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .loadPulse(loadPulse),
    .pwrDownN (pwrDownN),
    .strobes  (strobes),
    .outEn    (outEn)
  );

  pxl_ser_dp #(
    .LANES     (LANES),
    .SLOTS     (SLOTS),
    .HIGH_SLOTS(HIGH_SLOTS)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .pixWord (pixWord),
    .laneData(laneData),
    .clkLane (clkLane)
  );

endmodule

// File: rtl/pxl_link_ser_chk.sv
module pxl_link_ser_chk #(
  parameter int LANES      = 3,
  parameter int SLOTS      = 7,
  parameter int HIGH_SLOTS = 4,
  localparam int WORD_W    = LANES * SLOTS,
  localparam int CW        = $clog2(SLOTS + 1) + 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              loadPulse,
  input logic              pwrDownN,
  input logic [WORD_W-1:0] pixWord,
  input logic [LANES-1:0]  laneData,
  input logic              clkLane,
  input logic              outEn
);

  logic [LANES-1:0] slot0Vec;
  for (genvar l = 0; l < LANES; l++) begin : g_s0
    assign slot0Vec[l] = pixWord[l*SLOTS];
  end

  // Cycles since the last accepted load, saturating at SLOTS (idle).
  logic [CW-1:0] sinceLoad;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      sinceLoad <= CW'(SLOTS);
    else if (!pwrDownN)              sinceLoad <= CW'(SLOTS);
    else if (loadPulse)              sinceLoad <= '0;
    else if (sinceLoad < CW'(SLOTS)) sinceLoad <= sinceLoad + 1'b1;
  end

  AST_LOAD_SLOT0: assert property (@(posedge clk) disable iff (!rst_n)
    (loadPulse && pwrDownN) |=> (laneData == $past(slot0Vec))); // R2

  AST_CLK_HIGH_PART: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceLoad < CW'(HIGH_SLOTS)) |-> clkLane); // R4

  AST_CLK_LOW_PART: assert property (@(posedge clk) disable iff (!rst_n)
    ((sinceLoad >= CW'(HIGH_SLOTS)) && (sinceLoad < CW'(SLOTS))) |-> !clkLane); // R4

  AST_IDLE_AFTER_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (sinceLoad == CW'(SLOTS)) |-> (laneData == '0 && !clkLane)); // R5

  AST_OUTEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
    pwrDownN |=> outEn); // R6

  AST_PWRDN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !pwrDownN |=> (!outEn && laneData == '0 && !clkLane)); // R7

endmodule

bind pxl_link_ser pxl_link_ser_chk #(
  .LANES     (LANES),
  .SLOTS     (SLOTS),
  .HIGH_SLOTS(HIGH_SLOTS)
) chk_i (.*);

// File: tb/pxl_link_ser_tb_top.sv
module pxl_link_ser_tb_top;

  localparam int LANES = 3;
  localparam int SLOTS = 7;
  localparam int WW    = LANES * SLOTS;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          loadPulse = 1'b0;
  logic          pwrDownN = 1'b0;
  logic [WW-1:0] pixWord = '0;
  logic [LANES-1:0] laneData;
  logic          clkLane;
  logic          outEn;

  int    nChecks = 0;
  int    nBad = 0;
  bit    done = 0;
  string phaseTag = "reset";

  always #4 clk = ~clk;

  pxl_link_ser dut_i (
    .clk(clk), .rst_n(rst_n), .loadPulse(loadPulse), .pwrDownN(pwrDownN),
    .pixWord(pixWord), .laneData(laneData), .clkLane(clkLane), .outEn(outEn)
  );

  // Behavioural model: slot index since the last accepted load, -1 when idle.
  int          slotPos = -1;
  bit          enExp = 0;
  logic [WW-1:0] heldWord = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slotPos = -1; enExp = 0;
    end else if (!pwrDownN) begin
      slotPos = -1; enExp = 0;       // R7 flush, R8 loads refused
    end else begin
      enExp = 1;
      if (loadPulse) begin
        heldWord = pixWord; slotPos = 0;   // R2, R9 restart
      end else if (slotPos >= 0) begin
        slotPos++;
        if (slotPos >= SLOTS) slotPos = -1; // R5
      end
    end
  end

  task automatic check(input string req, input int got, input int exp);
    nChecks++;
    if (got != exp) begin
      nBad++;
      $display("FAIL %s [%s] got=%0h exp=%0h at %0t", req, phaseTag, got, exp, $time);
    end
  endtask

  // Compare on every falling edge, away from the active edge.
  always @(negedge clk) begin
    if (!done) begin
      logic [LANES-1:0] expLanes;
      string rq;
      for (int l = 0; l < LANES; l++)
        expLanes[l] = (slotPos >= 0) ? heldWord[l*SLOTS + slotPos] : 1'b0;
      if (!rst_n) rq = "R1";
      else if (!enExp) rq = "R7";
      else if (slotPos < 0) rq = "R5";
      else rq = "R3";
      check(rq, int'(laneData), int'(expLanes));
      if (rst_n && enExp && slotPos >= 0) rq = "R4";
      check(rq, int'(clkLane), (slotPos >= 0 && slotPos < 4) ? 1 : 0);
      check(rst_n ? "R6" : "R1", int'(outEn), int'(enExp));
    end
  end

  // Load one word; the next call lands exactly SLOTS cycles later when gap=0.
  task automatic sendWord(input logic [WW-1:0] w, input int gap);
    @(negedge clk); loadPulse = 1'b1; pixWord = w;
    @(negedge clk); loadPulse = 1'b0; pixWord = ~w;   // R10 noise on idle edges
    repeat (SLOTS - 2 + gap) @(negedge clk);
  endtask

  initial begin
    logic [WW-1:0] lfsr;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); pwrDownN = 1'b1;
    phaseTag = "R6 power up"; repeat (2) @(negedge clk);

    phaseTag = "R2 R3 solid patterns";
    sendWord(21'h1FFFFF, 0); sendWord(21'h000000, 0);
    sendWord(21'h155555, 0); sendWord(21'h0AAAAA, 0);

    phaseTag = "R3 walking one";
    for (int i = 0; i < WW; i++) sendWord(WW'(1) << i, 0);

    phaseTag = "R2 R10 pseudo random back to back";
    lfsr = 21'h13579;
    for (int i = 0; i < 12; i++) begin
      lfsr = {lfsr[19:0], lfsr[20] ^ lfsr[18]};
      sendWord(lfsr, 0);
    end

    phaseTag = "R5 gap to idle";
    sendWord(21'h0F0F0F, 10);

    phaseTag = "R9 early reload";
    @(negedge clk); loadPulse = 1'b1; pixWord = 21'h1FFFFF;
    @(negedge clk); loadPulse = 1'b0;
    repeat (2) @(negedge clk);
    sendWord(21'h000001, 4);

    phaseTag = "R7 R8 power down mid word";
    @(negedge clk); loadPulse = 1'b1; pixWord = 21'h1ABCDE;
    @(negedge clk); loadPulse = 1'b0;
    repeat (2) @(negedge clk);
    pwrDownN = 1'b0;
    repeat (3) begin
      @(negedge clk); loadPulse = 1'b1; pixWord = 21'h1FFFFF;  // R8 refused
    end
    @(negedge clk); loadPulse = 1'b0;
    repeat (8) @(negedge clk);
    pwrDownN = 1'b1;
    phaseTag = "R7 stays quiet after wake";
    repeat (10) @(negedge clk);
    phaseTag = "R2 after wake";
    sendWord(21'h0C3A5F, 8);

    done = 1;
    $display("test done: total=%0d bad=%0d", nChecks, nBad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!done) begin
      done = 1;
      nBad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", nChecks, nBad);
      $finish;
    end
  end

endmodule